// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block turns single-cycle access requests from a processor core into the pin-level waveforms of a narrow external memory bus. The low address byte and the data byte travel over one shared byte lane. A latch strobe tells the outside address latch when the lane holds an address. The high address byte has its own pins. Program fetches use a program-store strobe. Data reads and writes use separate active-low read and write strobes. Every edge is placed in whole input-clock periods.

The core presents a request with a kind, an address, write data and a flag that says whether the target lies outside the chip. The block accepts it at the end of the current slot. Fetch and idle slots last 6 periods. External data slots last 12 periods, and only the first of their two latch pulses is issued. Returned bytes appear on `rdata` with a one-cycle `rdata_valid` pulse.

A quiet mode, set through a one-bit auxiliary write port, holds the latch strobe low while nothing goes off-chip. Any external access brings the pulse back for its own slot. The strobe goes quiet again once that access has finished.

Top module: `xbus_seq`

## Requirements
- R1: `ale` is high for exactly 2 consecutive periods per pulse. In idle, internal and fetch slots it pulses once every 6 periods, which gives two pulses per 12-period machine cycle.
- R2: For an external access, `ad_oe` is high and `ad_out` carries address bits [7:0] in the period before `ale` falls and in the period right after it falls.
- R3: In an external fetch, `psen_n` goes low 1 period after `ale` falls and stays low for 3 periods. While it is low the lane is released (`ad_oe` low). The byte on `ad_in` in its last low period is returned on `rdata` with `rdata_valid` high for one cycle.
- R4: An external read or write slot lasts 12 periods and issues only one `ale` pulse. The second pulse is skipped.
- R5: In an external read or write, `rd_n` or `wr_n` goes low 3 periods after `ale` falls and stays low for 6 periods. `psen_n` stays high for the whole data slot.
- R6: In a write, `ad_oe` is high and `ad_out` holds the write data from 1 period before `wr_n` falls until 1 period after it rises.
- R7: In a read, the lane is released while `rd_n` is low. The byte on `ad_in` in the last low period is returned on `rdata` with a one-cycle `rdata_valid` pulse.
- R8: `a_hi` equals address bits [15:8] of the current external access and does not change while any strobe is low.
- R9: When `aux_we` is high, the quiet bit is loaded from `aux_ale_off`. While the bit is 1, `ale` stays low in idle and internal slots, pulses for each external access, and is low again afterwards.
- R10: During and right after reset, the quiet bit is 0, `ale` is low, all three strobes are high, the lane is released, `rdata_valid` is low and `req_take` is high.
- R11: A request is sampled at a rising edge where `req_take` is high, which happens in the last period of each slot. `req_kind` encodes 0 = fetch, 1 = read, 2 = write, 3 = none. A request with kind 3 or with `req_valid` low gives an idle slot with no strobe activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; one period is the timing unit |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 none |
| req_ext | input | 1 | Target is external (1) or internal (0) |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_take | output | 1 | Request is sampled at the next rising edge |
| aux_we | input | 1 | Load the quiet bit |
| aux_ale_off | input | 1 | New value of the quiet bit |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Value driven on the shared lane |
| ad_oe | output | 1 | Lane drive enable |
| ad_in | input | 8 | Value sampled from the shared lane |
| a_hi | output | 8 | High address byte |
| rdata | output | 8 | Returned byte |
| rdata_valid | output | 1 | One-cycle pulse marking `rdata` |

## Verification
The in-module assertions check the local shape of the waveforms on every cycle:

- the latch pulse width;
- the strobe widths;
- mutual exclusion of the strobes;
- release of the lane under a read-type strobe;
- write-data setup and hold around the write strobe;
- the stability of the high address byte;
- the single-cycle return pulse.

Only the bench scenarios can show the slot-level properties:

- pulse rates over windows of many slots;
- the skipped pulse in data slots;
- the on/off behaviour of the quiet mode around external and internal accesses;
- that the returned and written bytes match the addresses the core asked for.

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          req_ext,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_take,
  input  logic          aux_we,
  input  logic          aux_ale_off,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [AW-DW-1:0] a_hi,
  output logic [DW-1:0] rdata,
  output logic          rdata_valid
);
  localparam int SLOT  = 6;
  localparam int DSLOT = 2 * SLOT;
  localparam int PH_W  = $clog2(DSLOT);
  localparam logic [PH_W-1:0] LAST_S = PH_W'(SLOT - 1);
  localparam logic [PH_W-1:0] LAST_D = PH_W'(DSLOT - 1);

  localparam logic [1:0] K_FETCH = 2'd0;
  localparam logic [1:0] K_READ  = 2'd1;
  localparam logic [1:0] K_WRITE = 2'd2;
  localparam logic [1:0] K_NONE  = 2'd3;

  logic [PH_W-1:0] ph_q;
  logic [1:0]      op_q;
  logic            ext_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wd_q;
  logic            quiet_q;

  logic is_fetch, is_rd, is_wr, is_data, bus_op;
  logic addr_ph, wdat_ph;

  assign is_fetch = ext_q && (op_q == K_FETCH);
  assign is_rd    = ext_q && (op_q == K_READ);
  assign is_wr    = ext_q && (op_q == K_WRITE);
  assign is_data  = is_rd || is_wr;
  assign bus_op   = is_fetch || is_data;

  assign req_take = (ph_q == (is_data ? LAST_D : LAST_S));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q        <= LAST_S;
      op_q        <= K_NONE;
      ext_q       <= 1'b0;
      addr_q      <= '0;
      wd_q        <= '0;
      quiet_q     <= 1'b0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      if (aux_we) quiet_q <= aux_ale_off;
      rdata_valid <= 1'b0;
      if ((is_fetch && ph_q == PH_W'(5)) || (is_rd && ph_q == PH_W'(10))) begin
        rdata       <= ad_in;
        rdata_valid <= 1'b1;
      end
      if (req_take) begin
        ph_q <= '0;
        if (req_valid && req_kind != K_NONE) begin
          op_q  <= req_kind;
          ext_q <= req_ext;
          if (req_ext) begin
            addr_q <= req_addr;
            wd_q   <= req_wdata;
          end
        end else begin
          op_q  <= K_NONE;
          ext_q <= 1'b0;
        end
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign addr_ph = (ph_q == PH_W'(1)) || (ph_q == PH_W'(2));
  assign wdat_ph = is_wr && (ph_q >= PH_W'(4)) && (ph_q <= PH_W'(11));

  assign ale    = ((ph_q == PH_W'(0)) || (ph_q == PH_W'(1))) && (!quiet_q || bus_op);
  assign psen_n = !(is_fetch && ph_q >= PH_W'(3) && ph_q <= PH_W'(5));
  assign rd_n   = !(is_rd && ph_q >= PH_W'(5) && ph_q <= PH_W'(10));
  assign wr_n   = !(is_wr && ph_q >= PH_W'(5) && ph_q <= PH_W'(10));
  assign ad_oe  = (bus_op && addr_ph) || wdat_ph;
  assign ad_out = wdat_ph ? wd_q : addr_q[DW-1:0];
  assign a_hi   = addr_q[AW-1:DW];

  AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale ##1 !ale); // R1
  AST_ADDR_AROUND_FALL: assert property (@(posedge clk) disable iff (rst)
    ($fell(ale) && ad_oe) |-> $past(ad_oe) && $stable(ad_out)); // R2
  AST_PSEN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n) |=> !psen_n ##1 !psen_n ##1 psen_n); // R3
  AST_LANE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n) |-> !ad_oe); // R7
  AST_SKIP_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> !ale); // R4
  AST_RD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n) |=> !rd_n ##1 !rd_n ##1 !rd_n ##1 !rd_n ##1 !rd_n ##1 rd_n); // R5
  AST_WR_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |=> !wr_n ##1 !wr_n ##1 !wr_n ##1 !wr_n ##1 !wr_n ##1 wr_n); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> (rd_n && wr_n)); // R5
  AST_WR_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> $past(ad_oe) && $stable(ad_out)); // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> ad_oe && $stable(ad_out)); // R6
  AST_HI_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n || !wr_n) |-> $stable(a_hi)); // R8
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rdata_valid |=> !rdata_valid); // R3
endmodule

// File: tb/xbus_seq_bench.sv
module xbus_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd3;
  logic req_ext = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic aux_we = 1'b0;
  logic aux_ale_off = 1'b0;
  logic req_take, ale, psen_n, rd_n, wr_n, ad_oe, rdata_valid;
  logic [7:0] ad_out, ad_in, a_hi, rdata;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct packed {
    logic [1:0]  k;
    logic [15:0] a;
    logic [7:0]  d;
  } item_t;
  item_t exp_q[$];

  logic [15:0] lat_addr = '0;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return {a[14:8], a[15]} ^ a[7:0] ^ 8'h5A;
  endfunction

  assign ad_in = mem_byte(lat_addr);

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_seq u_xbus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_ext(req_ext), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_take(req_take), .aux_we(aux_we), .aux_ale_off(aux_ale_off),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi),
    .rdata(rdata), .rdata_valid(rdata_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pop_cmp(input logic [1:0] k, input logic [7:0] d, input string tag);
    item_t it;
    if (exp_q.size() == 0) begin
      chk(1'b0, {tag, " unexpected result"}, d, 0);
    end else begin
      it = exp_q.pop_front();
      chk(it.k == k, {tag, " kind"}, k, it.k);
      chk(it.a == lat_addr, {tag, " address"}, lat_addr, it.a);
      chk(it.d == d, {tag, " data"}, d, it.d);
    end
  endtask

  bit p_ale = 0, p_oe = 0, p_psen = 1, p_rd = 1, p_wr = 1;
  logic [7:0] p_out = '0;
  logic [7:0] wd_seen = '0;
  logic [1:0] last_k = 2'd0;
  int t = 0, ale_run = 0, ale_rises = 0, strobe_falls = 0, takes = 0;
  int low_len = 0, ale_in_low = 0;
  bit bad_lane = 0, bad_hi = 0, bad_psen = 0, bad_wd = 0;

  always @(negedge clk) begin
    if (rst) begin
      p_ale = 0; p_oe = 0; p_psen = 1; p_rd = 1; p_wr = 1; p_out = '0; ale_run = 0;
    end else begin
      if (req_take) takes++;
      if (ale && !p_ale) ale_rises++;
      if (ale) ale_run++;
      if (p_ale && !ale) begin
        chk(ale_run == 2, "R1 latch pulse width", ale_run, 2);
        if (ad_oe) begin
          chk(p_oe && p_out == ad_out, "R2 address around latch fall", p_out, ad_out);
          lat_addr = {a_hi, ad_out};
        end
        ale_run = 0;
        t = 0;
      end else begin
        t++;
      end

      if (p_psen && !psen_n) begin
        strobe_falls++;
        chk(t == 1, "R3 fetch strobe start", t, 1);
        low_len = 0; bad_lane = 0; bad_hi = 0;
      end
      if (p_rd && !rd_n) begin
        strobe_falls++;
        chk(t == 3, "R5 read strobe start", t, 3);
        low_len = 0; bad_lane = 0; bad_hi = 0; bad_psen = 0; ale_in_low = 0;
      end
      if (p_wr && !wr_n) begin
        strobe_falls++;
        chk(t == 3, "R5 write strobe start", t, 3);
        chk(p_oe && ad_oe && p_out == ad_out, "R6 data before write strobe", p_out, ad_out);
        wd_seen = ad_out;
        low_len = 0; bad_hi = 0; bad_psen = 0; bad_wd = 0; ale_in_low = 0;
      end

      if (!psen_n || !rd_n || !wr_n) begin
        low_len++;
        if (a_hi !== lat_addr[15:8]) bad_hi = 1;
        if (ale) ale_in_low++;
      end
      if ((!psen_n || !rd_n) && ad_oe) bad_lane = 1;
      if ((!rd_n || !wr_n) && !psen_n) bad_psen = 1;
      if (!wr_n && (!ad_oe || ad_out !== wd_seen)) bad_wd = 1;

      if (!p_psen && psen_n) begin
        chk(low_len == 3, "R3 fetch strobe width", low_len, 3);
        chk(!bad_lane, "R3 lane released during fetch", bad_lane, 0);
        chk(!bad_hi, "R8 high byte stable in fetch", bad_hi, 0);
        last_k = 2'd0;
      end
      if (!p_rd && rd_n) begin
        chk(low_len == 6, "R5 read strobe width", low_len, 6);
        chk(!bad_lane, "R7 lane released during read", bad_lane, 0);
        chk(!bad_psen, "R5 program strobe idle in read", bad_psen, 0);
        chk(ale_in_low == 0, "R4 second latch pulse skipped", ale_in_low, 0);
        chk(!bad_hi, "R8 high byte stable in read", bad_hi, 0);
        last_k = 2'd1;
      end
      if (!p_wr && wr_n) begin
        chk(low_len == 6, "R5 write strobe width", low_len, 6);
        chk(!bad_wd, "R6 data stable under write strobe", bad_wd, 0);
        chk(ad_oe && ad_out == wd_seen, "R6 data hold after write strobe", ad_out, wd_seen);
        chk(!bad_psen, "R5 program strobe idle in write", bad_psen, 0);
        chk(ale_in_low == 0, "R4 second latch pulse skipped", ale_in_low, 0);
        chk(!bad_hi, "R8 high byte stable in write", bad_hi, 0);
        pop_cmp(2'd2, wd_seen, "R6 write");
      end
      if (rdata_valid) begin
        if (last_k == 2'd0) pop_cmp(2'd0, rdata, "R3 fetch return");
        else pop_cmp(2'd1, rdata, "R7 read return");
      end

      p_ale = ale; p_oe = ad_oe; p_out = ad_out;
      p_psen = psen_n; p_rd = rd_n; p_wr = wr_n;
    end
  end

  task automatic wait_take();
    do @(negedge clk); while (!req_take);
  endtask

  task automatic issue(input logic [1:0] k, input bit e, input logic [15:0] a, input logic [7:0] d);
    item_t it;
    wait_take();
    if (e && k != 2'd3) begin
      it.k = k;
      it.a = a;
      it.d = (k == 2'd2) ? d : mem_byte(a);
      exp_q.push_back(it);
    end
    req_valid = 1'b1; req_kind = k; req_ext = e; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_kind = 2'd3; req_ext = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (exp_q.size() != 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_quiet(input bit v);
    wait_take();
    aux_we = 1'b1; aux_ale_off = v;
    @(negedge clk);
    aux_we = 1'b0;
  endtask

  int r0, tk0, sf0;

  initial begin
    repeat (3) @(negedge clk);
    chk(ale == 1'b0, "R10 latch strobe low in reset", ale, 0);
    chk(psen_n && rd_n && wr_n, "R10 strobes idle in reset", {psen_n, rd_n, wr_n}, 3'b111);
    chk(!ad_oe, "R10 lane released in reset", ad_oe, 0);
    chk(!rdata_valid, "R10 no return in reset", rdata_valid, 0);
    chk(req_take, "R10 ready at reset release", req_take, 1);
    rst = 1'b0;

    // R11: requests of kind none leave slots idle; R1: pulse rate
    req_valid = 1'b1; req_kind = 2'd3; req_ext = 1'b1;
    r0 = ale_rises; tk0 = takes; sf0 = strobe_falls;
    repeat (60) @(negedge clk);
    chk(ale_rises - r0 == 10, "R1 pulse every 6 periods", ale_rises - r0, 10);
    chk(takes - tk0 == 10, "R11 one take per slot", takes - tk0, 10);
    chk(strobe_falls == sf0, "R11 no strobes on idle slots", strobe_falls - sf0, 0);
    chk(ale_rises - r0 == 10, "R10 quiet bit clear after reset", ale_rises - r0, 10);
    req_valid = 1'b0; req_ext = 1'b0;

    issue(2'd0, 1'b1, 16'h1234, 8'h00);
    issue(2'd0, 1'b1, 16'hFF00, 8'h00);
    issue(2'd0, 1'b1, 16'h00FF, 8'h00);
    issue(2'd0, 1'b1, 16'hA5C3, 8'h00);
    drain();

    issue(2'd1, 1'b1, 16'h8001, 8'h00);
    issue(2'd1, 1'b1, 16'h7FFE, 8'h00);
    drain();

    issue(2'd2, 1'b1, 16'h4000, 8'h3C);
    issue(2'd2, 1'b1, 16'hFFFF, 8'hC3);
    drain();

    issue(2'd0, 1'b1, 16'h0102, 8'h00);
    issue(2'd2, 1'b1, 16'h0304, 8'h99);
    issue(2'd1, 1'b1, 16'h0506, 8'h00);
    issue(2'd0, 1'b1, 16'hBEEF, 8'h00);
    drain();

    // R9: quiet mode
    set_quiet(1'b1);
    r0 = ale_rises;
    repeat (36) @(negedge clk);
    chk(ale_rises == r0, "R9 quiet in idle slots", ale_rises - r0, 0);

    r0 = ale_rises;
    issue(2'd0, 1'b1, 16'h2468, 8'h00);
    drain();
    repeat (8) @(negedge clk);
    chk(ale_rises - r0 == 1, "R9 pulse back for external fetch", ale_rises - r0, 1);

    r0 = ale_rises;
    repeat (24) @(negedge clk);
    chk(ale_rises == r0, "R9 quiet again after fetch", ale_rises - r0, 0);

    r0 = ale_rises;
    issue(2'd1, 1'b1, 16'h9ABC, 8'h00);
    drain();
    repeat (8) @(negedge clk);
    chk(ale_rises - r0 == 1, "R9 single pulse for external read", ale_rises - r0, 1);

    r0 = ale_rises; sf0 = strobe_falls;
    issue(2'd0, 1'b0, 16'h1111, 8'h00);
    repeat (12) @(negedge clk);
    chk(ale_rises == r0, "R9 internal fetch stays quiet", ale_rises - r0, 0);
    chk(strobe_falls == sf0, "R9 internal fetch has no strobe", strobe_falls - sf0, 0);

    set_quiet(1'b0);
    wait_take();
    r0 = ale_rises;
    repeat (30) @(negedge clk);
    chk(ale_rises - r0 == 5, "R9 pulses restored when bit cleared", ale_rises - r0, 5);

    chk(exp_q.size() == 0, "R11 every request answered", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired R11 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule